// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block holds the program counter of a small processor front end and pre-decodes one 16-bit instruction word per clock from a byte-addressed program store. Every word sits at an even byte address, so the PC moves in steps of two and its bit 0 is always zero. Each fetched word falls into one of three classes: a normal single-word instruction, the leading word of a two-word instruction, or a word with top nibble 1111 that appears on its own. Words of the last class normally trail a leading word.

When a leading word arrives, the sequencer holds it and fetches the trailing word on the next cycle. It then presents both words together as one instruction. The trailing word's low twelve bits are the operand. For the absolute jump and subroutine-call pairs, the sequencer builds the 20-bit word target and loads it into PC bits 20:1. Single-word relative branches add twice their signed word offset to the address of the following word. The execute stage can ask to skip the word under decode. If that skip lands on a lone trailing word, the word comes out as a NOP. This keeps a one-word skip safe in front of a two-word instruction.

The program store is a synchronous word array that is written through a load port. Execution, the register file and the return stack live elsewhere. A call is reported only through its target address.

Top module: `fetch_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `pc` is 0 and `out_valid` is 0. The word at byte 0 is decoded on the second cycle after reset falls.
- R2: `pc` bit 0 is always 0. After a single-word instruction that does not branch, the next word is decoded at `pc + 2`.
- R3: These words lead a two-word pair: top nibble C (move), top byte EF (goto), top seven bits 1110110 (call), and top ten bits 1110111000 (load-pointer). A leading word produces no output on its own cycle, and `pc` advances by 2.
- R4: On the cycle after a leading word, the trailing word is output together with it: `out_two` = 1, `out_first` = leading word, `out_second` = trailing word, and `out_pc` = address of the leading word. A pair that does not jump moves the PC 4 bytes in total.
- R5: For a goto or call pair, `out_jump` = 1 and the next PC is {trailing[11:0], leading[7:0], 0}. Leading word EF03h with trailing word F000h goes to byte 000006h.
- R6: A single word with top nibble D is a relative branch. Its next PC is `pc + 2 + 2*sext(word[10:0])`, and `out_jump` = 1.
- R7: A word with top nibble F that is decoded without a leading word is output with `out_nop` = 1 and `out_two` = 0. The next PC is `pc + 2`.
- R8: `skip_req` high on a cycle that is not completing a pair discards the current word: no output, and `pc` advances by exactly 2.
- R9: `skip_req` is ignored while a pair is completing. The pair is output unchanged and follows its normal next PC.
- R10: For a move pair, the source address is `out_first[11:0]` and the destination address is `out_second[11:0]`. C123h followed by F456h gives 123h and 456h.
- R11: Whenever `out_valid` is 1, `out_target` equals the PC of the next word to be decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Program store write enable |
| ld_addr | input | AW | Program store word index |
| ld_data | input | 16 | Program store write word |
| skip_req | input | 1 | Discard the word being decoded |
| pc | output | PCW | Byte address of the word under decode |
| out_valid | output | 1 | An instruction is presented this cycle |
| out_pc | output | PCW | Byte address of the presented instruction |
| out_first | output | 16 | Instruction word, or leading word of a pair |
| out_second | output | 16 | Trailing word of a pair, else 0 |
| out_two | output | 1 | Presented instruction is a pair |
| out_nop | output | 1 | Lone trailing word executed as NOP |
| out_jump | output | 1 | Control flow leaves sequential order |
| out_target | output | PCW | Next PC after this instruction |

## Verification
A bad pending flag shows up at the ports on the very next decode cycle. A pair would then be split into a lone NOP, or an unrelated word would be glued onto a held leading word. A corrupted PC or assembled target is visible on the following cycle, because the fetched word, `pc` and `out_pc` all diverge from the expected program walk. The bench runs a word-by-word model alongside the design over directed programs and many randomly built ones, with random skips. It compares every output on every cycle, so any divergence is reported within one cycle of the fault.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int PCW = 21,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic [AW-1:0]  ld_addr,
  input  logic [15:0]    ld_data,
  input  logic           skip_req,
  output logic [PCW-1:0] pc,
  output logic           out_valid,
  output logic [PCW-1:0] out_pc,
  output logic [15:0]    out_first,
  output logic [15:0]    out_second,
  output logic           out_two,
  output logic           out_nop,
  output logic           out_jump,
  output logic [PCW-1:0] out_target
);

  localparam int DEPTH = 2 ** AW;

  function automatic logic is_ctl(input logic [15:0] w);
    return (w[15:8] == 8'hEF) || (w[15:9] == 7'b1110110);
  endfunction

  function automatic logic is_lead(input logic [15:0] w);
    return (w[15:12] == 4'hC) || is_ctl(w) || (w[15:6] == 10'b1110111000);
  endfunction

  logic [15:0]    mem [DEPTH];
  logic [15:0]    mem_q, first_q;
  logic           primed, pend, pend_n, hold_first;
  logic [PCW-1:0] nxt, seq, abs_tgt, rel_tgt;

  assign seq     = pc + PCW'(2);
  assign abs_tgt = PCW'({mem_q[11:0], first_q[7:0], 1'b0});
  assign rel_tgt = seq + PCW'({{(PCW-12){mem_q[10]}}, mem_q[10:0], 1'b0});

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk)
    mem_q <= mem[nxt[AW:1]];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      primed  <= 1'b0;
      pend    <= 1'b0;
      first_q <= '0;
    end else begin
      pc     <= nxt;
      primed <= 1'b1;
      pend   <= pend_n;
      if (hold_first) first_q <= mem_q;
    end
  end

  always_comb begin
    nxt        = pc;
    pend_n     = pend;
    hold_first = 1'b0;
    out_valid  = 1'b0;
    out_two    = 1'b0;
    out_nop    = 1'b0;
    out_jump   = 1'b0;
    out_first  = mem_q;
    out_second = '0;
    out_pc     = pc;
    if (!primed) begin
      nxt = pc;
    end else if (pend) begin
      out_valid  = 1'b1;
      out_two    = 1'b1;
      out_first  = first_q;
      out_second = mem_q;
      out_pc     = pc - PCW'(2);
      pend_n     = 1'b0;
      if (is_ctl(first_q)) begin
        out_jump = 1'b1;
        nxt      = abs_tgt;
      end else begin
        nxt = seq;
      end
    end else if (skip_req) begin
      nxt = seq;
    end else if (is_lead(mem_q)) begin
      nxt        = seq;
      pend_n     = 1'b1;
      hold_first = 1'b1;
    end else if (mem_q[15:12] == 4'hF) begin
      out_valid = 1'b1;
      out_nop   = 1'b1;
      nxt       = seq;
    end else if (mem_q[15:12] == 4'hD) begin
      out_valid = 1'b1;
      out_jump  = 1'b1;
      nxt       = rel_tgt;
    end else begin
      out_valid = 1'b1;
      nxt       = seq;
    end
  end

  assign out_target = nxt;

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (pc == '0 && !out_valid));
  assert_pc_even_R2: assert property (@(posedge clk) disable iff (rst) pc[0] == 1'b0);
  assert_pair_closes_R4: assert property (@(posedge clk) disable iff (rst) pend |=> !pend);
  assert_pair_shown_R4: assert property (@(posedge clk) disable iff (rst) pend |-> (out_valid && out_two));
  assert_nop_alone_R7: assert property (@(posedge clk) disable iff (rst) out_nop |-> !out_two);
  assert_skip_step_R8: assert property (@(posedge clk) disable iff (rst)
    (primed && !pend && skip_req) |=> (pc == $past(pc) + PCW'(2)));
  assert_target_taken_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (pc == $past(out_target)));

endmodule

// File: tb/fetch_seq_test.sv
`timescale 1ns/1ps
module fetch_seq_test;
  localparam int PCW = 21;
  localparam int AW  = 6;
  localparam int N   = 64;

  logic clk = 1'b0, rst = 1'b1, ld_en = 1'b0, skip_req = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [PCW-1:0] pc, out_pc, out_target;
  logic out_valid, out_two, out_nop, out_jump;
  logic [15:0] out_first, out_second;

  fetch_seq #(.PCW(PCW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .skip_req(skip_req), .pc(pc), .out_valid(out_valid), .out_pc(out_pc),
    .out_first(out_first), .out_second(out_second), .out_two(out_two),
    .out_nop(out_nop), .out_jump(out_jump), .out_target(out_target));

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  logic [15:0] prog [N];
  logic [PCW-1:0] m_pc;
  bit m_pend;
  logic [15:0] m_first;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  function automatic bit m_ctl(input logic [15:0] w);
    return (w[15:8] == 8'hEF) || (w[15:9] == 7'b1110110);
  endfunction

  function automatic bit m_lead(input logic [15:0] w);
    return (w[15:12] == 4'hC) || m_ctl(w) || (w[15:6] == 10'b1110111000);
  endfunction

  task automatic load_and_reset();
    rst = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    chk(pc == '0 && !out_valid, "R1", "reset state", {pc, out_valid}, '0);
    rst = 1'b0;
    #1;
    chk(pc == '0 && !out_valid, "R1", "priming cycle", {pc, out_valid}, '0);
    m_pc = '0; m_pend = 0; m_first = '0;
  endtask

  task automatic step(input bit sk);
    logic [15:0] w, ef, es;
    logic [PCW-1:0] etg, eipc;
    bit ev, en, et, ej;
    string tag;
    @(negedge clk);
    skip_req = sk;
    #1;
    w = prog[m_pc[AW:1]];
    ev = 0; en = 0; et = 0; ej = 0; ef = w; es = '0;
    eipc = m_pc; etg = m_pc + 2; tag = "R2";
    if (m_pend) begin
      ev = 1; et = 1; ef = m_first; es = w; eipc = m_pc - 2;
      if (m_ctl(m_first)) begin
        ej = 1; etg = PCW'({w[11:0], m_first[7:0], 1'b0}); tag = "R5";
      end else tag = (m_first[15:12] == 4'hC) ? "R10" : "R4";
      if (sk) tag = "R9";
      m_pend = 0;
    end else if (sk) tag = "R8";
    else if (m_lead(w)) begin
      tag = "R3"; m_pend = 1; m_first = w;
    end else if (w[15:12] == 4'hF) begin
      ev = 1; en = 1; tag = "R7";
    end else if (w[15:12] == 4'hD) begin
      ev = 1; ej = 1; tag = "R6";
      etg = m_pc + 2 + PCW'({{9{w[10]}}, w[10:0], 1'b0});
    end else ev = 1;
    chk(pc == m_pc, tag, "pc", 32'(pc), 32'(m_pc));
    chk(out_valid == ev, tag, "valid", 32'(out_valid), 32'(ev));
    if (ev) begin
      chk(out_first == ef && out_second == es, tag, "words",
          {out_first, out_second}, {ef, es});
      chk(out_two == et && out_nop == en && out_jump == ej, tag, "flags",
          {out_two, out_nop, out_jump}, {et, en, ej});
      chk(out_target == etg, "R11", "target", 32'(out_target), 32'(etg));
      chk(out_pc == eipc, tag, "out_pc", 32'(out_pc), 32'(eipc));
    end
    m_pc = etg;
  endtask

  task automatic directed(input int skip_at);
    for (int i = 0; i < N; i++) prog[i] = 16'h2400;
    prog[0] = 16'h6600; prog[1] = 16'hC123; prog[2] = 16'hF456;
    prog[3] = 16'h2400; prog[4] = 16'hEF03; prog[5] = 16'hF000;
    load_and_reset();
    for (int c = 0; c < 16; c++) step(skip_at >= 0 && m_pc == PCW'(skip_at));
  endtask

  task automatic random_prog();
    int i = 0;
    while (i < N) begin
      case ($urandom % 8)
        0: begin prog[i] = 16'h0E00 | 16'($urandom % 256); i++; end
        1: begin prog[i] = {4'hD, 1'($urandom), 11'(int'($urandom % 16) - 8)}; i++; end
        2: begin prog[i] = {8'hEF, 8'($urandom % 64)}; prog[(i+1)%N] = 16'hF000; i += 2; end
        3: begin prog[i] = {7'b1110110, 1'($urandom), 8'($urandom % 64)};
                 prog[(i+1)%N] = 16'hF000; i += 2; end
        4: begin prog[i] = {4'hC, 12'($urandom)}; prog[(i+1)%N] = {4'hF, 12'($urandom)}; i += 2; end
        5: begin prog[i] = {10'b1110111000, 6'($urandom)}; prog[(i+1)%N] = {8'hF0, 8'($urandom)}; i += 2; end
        6: begin prog[i] = {4'hF, 12'($urandom)}; i++; end
        default: begin prog[i] = 16'h2400 | 16'($urandom % 256); i++; end
      endcase
    end
  endtask

  initial begin
    directed(-1);
    directed(2);
    directed(4);
    for (int r = 0; r < 30; r++) begin
      random_prog();
      load_and_reset();
      for (int c = 0; c < 300; c++) step(($urandom % 4) == 0);
    end
    summary();
  end
endmodule